// File: doc/BRIEF.md
# Configurable edge set-reset latch

This block holds a single output bit that is set or cleared by edges on two signals picked by index from an input bit bus. One index chooses the set source and another chooses the clear source. Each source has its own edge setting: rising, falling, either, or off. An edge is found by comparing the selected bit with a registered copy of that bit from the previous clock. The output register then changes on the next clock edge.

An enable input gates all events. While the block is disabled, a disable-mode field controls the output: it can drive it low, drive it high, or keep its present value. While the block is enabled, two one-cycle strobes can force the output high or low. They override bus events in the same cycle. In every conflict the clearing action wins.

The control logic is a two-state machine. The states are `ST_LOW` (output 0) and `ST_HIGH` (output 1). The transition `SET` goes from `ST_LOW` to `ST_HIGH` when the arbiter issues a set command. The transition `CLEAR` goes from `ST_HIGH` to `ST_LOW` when the arbiter issues a clear command. With any other command the machine stays in its current state.

Top module: `edge_sr_latch`

## Requirements
- R1: When enabled with no strobe or clear event, an active edge on bus bit `set_sel` makes `q_out` 1 after the next rising clock edge.
- R2: When enabled with no strobe, an active edge on bus bit `rst_sel` makes `q_out` 0 after the next rising clock edge.
- R3: Edge fields are encoded 0 = rising, 1 = falling, 2 = either, 3 = off (never active). The set and clear fields act independently.
- R4: An edge field is applied to the edge seen in the same cycle it is written. A rising edge that coincides with a change to falling is ignored. A falling edge that coincides with a change to falling is taken.
- R5: With `enable` low and `dis_mode` 0 (or the reserved value 3), `q_out` becomes 0 and bus events and strobes are ignored.
- R6: With `enable` low and `dis_mode` 1, `q_out` becomes 1 and bus events and strobes are ignored.
- R7: With `enable` low and `dis_mode` 2, `q_out` keeps its value whatever the bus and the strobes do.
- R8: With `enable` high, `force_set` or `force_rst` sets or clears `q_out` on the next clock, overriding any bus event in that cycle.
- R9: Clearing wins when a clear and a set act in the same cycle: `force_rst` beats `force_set`, and a clear-source edge beats a set-source edge.
- R10: Synchronous reset makes `q_out` 0 and clears both stored previous samples to 0. A selected bit that is already 1 therefore counts as a rising edge in the first cycle after reset.
- R11: When enabled with no strobe and no active edge, `q_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_bus | input | BUS_W | Candidate input bits |
| set_sel | input | SEL_W | Index of the set source |
| rst_sel | input | SEL_W | Index of the clear source |
| set_edge | input | 2 | Edge setting of the set source |
| rst_edge | input | 2 | Edge setting of the clear source |
| dis_mode | input | 2 | Output behaviour while disabled |
| enable | input | 1 | High to accept events and strobes |
| force_set | input | 1 | One-cycle strobe to drive the output high |
| force_rst | input | 1 | One-cycle strobe to drive the output low |
| q_out | output | 1 | Latched output |

## Verification
On every cycle, the assertions check the next-cycle result of the disable modes, the strobe priorities, and the idle hold. These properties relate the enable, the strobes and the decoded events to `q_out`. Edge detection against the stored sample is not covered by the assertions. That includes an edge setting written in the same cycle as the edge, and the apparent rising edge after reset. Only the bench scenarios show this behaviour, because they track the previous bus samples in a reference model.

// File: rtl/edge_sr_pkg.sv
package edge_sr_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_OFF  = 2'd3
    } edge_mode_e;

    typedef enum logic [1:0] {
        DIS_LOW  = 2'd0,
        DIS_HIGH = 2'd1,
        DIS_HOLD = 2'd2,
        DIS_RSVD = 2'd3
    } dis_mode_e;

    typedef enum logic [1:0] {
        CMD_KEEP = 2'd0,
        CMD_SET  = 2'd1,
        CMD_CLR  = 2'd2
    } cmd_e;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } state_e;

endpackage

// File: rtl/esl_edge_pick.sv
module esl_edge_pick
    import edge_sr_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] bus_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [1:0]       mode_i,
    output logic             edge_o
);
    logic cur_bit;
    logic prev_bit;
    edge_mode_e mode;

    assign cur_bit = bus_i[sel_i];
    assign mode    = edge_mode_e'(mode_i);

    // previous sample of the selected bit, cleared by reset
    always_ff @(posedge clk) begin
        if (rst) prev_bit <= 1'b0;
        else     prev_bit <= cur_bit;
    end

    // the mode seen this cycle qualifies this cycle's edge
    always_comb begin
        unique case (mode)
            EDGE_RISE: edge_o = cur_bit & ~prev_bit;
            EDGE_FALL: edge_o = ~cur_bit & prev_bit;
            EDGE_BOTH: edge_o = cur_bit ^ prev_bit;
            EDGE_OFF:  edge_o = 1'b0;
            default:   edge_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/esl_event_arb.sv
module esl_event_arb
    import edge_sr_pkg::*;
(
    input  logic       enable_i,
    input  logic [1:0] dis_mode_i,
    input  logic       force_set_i,
    input  logic       force_rst_i,
    input  logic       set_ev_i,
    input  logic       rst_ev_i,
    output cmd_e       cmd_o
);
    dis_mode_e dmode;
    assign dmode = dis_mode_e'(dis_mode_i);

    always_comb begin
        cmd_o = CMD_KEEP;
        if (!enable_i) begin
            unique case (dmode)
                DIS_LOW:  cmd_o = CMD_CLR;
                DIS_HIGH: cmd_o = CMD_SET;
                DIS_HOLD: cmd_o = CMD_KEEP;
                DIS_RSVD: cmd_o = CMD_CLR;
                default:  cmd_o = CMD_CLR;
            endcase
        end else if (force_rst_i) begin
            cmd_o = CMD_CLR;
        end else if (force_set_i) begin
            cmd_o = CMD_SET;
        end else if (rst_ev_i) begin
            cmd_o = CMD_CLR;
        end else if (set_ev_i) begin
            cmd_o = CMD_SET;
        end
    end
endmodule

// File: rtl/esl_sr_fsm.sv
module esl_sr_fsm
    import edge_sr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_e cmd_i,
    output logic q_o
);
    state_e state_q;
    state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOW;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW:  if (cmd_i == CMD_SET) state_d = ST_HIGH;
            ST_HIGH: if (cmd_i == CMD_CLR) state_d = ST_LOW;
            default: state_d = ST_LOW;
        endcase
    end

    always_comb begin
        q_o = (state_q == ST_HIGH);
    end
endmodule

// File: rtl/edge_sr_latch.sv
module edge_sr_latch
    import edge_sr_pkg::*;
#(
    parameter int BUS_W = 32,
    localparam int SEL_W = (BUS_W > 1) ? $clog2(BUS_W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] bit_bus,
    input  logic [SEL_W-1:0] set_sel,
    input  logic [SEL_W-1:0] rst_sel,
    input  logic [1:0]       set_edge,
    input  logic [1:0]       rst_edge,
    input  logic [1:0]       dis_mode,
    input  logic             enable,
    input  logic             force_set,
    input  logic             force_rst,
    output logic             q_out
);
    logic set_ev;
    logic rst_ev;
    cmd_e cmd;

    esl_edge_pick #(.BUS_W(BUS_W), .SEL_W(SEL_W)) set_pick_i (
        .clk(clk), .rst(rst), .bus_i(bit_bus), .sel_i(set_sel),
        .mode_i(set_edge), .edge_o(set_ev)
    );

    esl_edge_pick #(.BUS_W(BUS_W), .SEL_W(SEL_W)) rst_pick_i (
        .clk(clk), .rst(rst), .bus_i(bit_bus), .sel_i(rst_sel),
        .mode_i(rst_edge), .edge_o(rst_ev)
    );

    esl_event_arb arb_i (
        .enable_i(enable), .dis_mode_i(dis_mode),
        .force_set_i(force_set), .force_rst_i(force_rst),
        .set_ev_i(set_ev), .rst_ev_i(rst_ev), .cmd_o(cmd)
    );

    esl_sr_fsm fsm_i (
        .clk(clk), .rst(rst), .cmd_i(cmd), .q_o(q_out)
    );

    // R5
    dis_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!enable && (dis_mode == 2'd0 || dis_mode == 2'd3)) |=> !q_out);

    // R6
    dis_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!enable && dis_mode == 2'd1) |=> q_out);

    // R7
    dis_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!enable && dis_mode == 2'd2) |=> (q_out == $past(q_out)));

    // R9
    force_clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && force_rst) |=> !q_out);

    // R8
    force_set_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && force_set && !force_rst) |=> q_out);

    // R2
    bus_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && !force_set && !force_rst && rst_ev) |=> !q_out);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && !force_set && !force_rst && !rst_ev && !set_ev) |=> $stable(q_out));
endmodule

// File: tb/edge_sr_latch_tb_top.sv
`timescale 1ns/1ps
module edge_sr_latch_tb_top;
    localparam int BUS_W = 32;
    localparam int SEL_W = $clog2(BUS_W);

    logic             clk = 1'b0;
    logic             rst;
    logic [BUS_W-1:0] bit_bus;
    logic [SEL_W-1:0] set_sel, rst_sel;
    logic [1:0]       set_edge, rst_edge, dis_mode;
    logic             enable, force_set, force_rst;
    logic             q_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    logic m_q, m_ps, m_pr;

    always #2 clk = ~clk;

    edge_sr_latch #(.BUS_W(BUS_W)) dut_i (
        .clk(clk), .rst(rst), .bit_bus(bit_bus),
        .set_sel(set_sel), .rst_sel(rst_sel),
        .set_edge(set_edge), .rst_edge(rst_edge), .dis_mode(dis_mode),
        .enable(enable), .force_set(force_set), .force_rst(force_rst),
        .q_out(q_out)
    );

    function automatic logic edge_hit(logic [1:0] m, logic cur, logic prv);
        case (m)
            2'd0:    return cur & ~prv;
            2'd1:    return ~cur & prv;
            2'd2:    return cur ^ prv;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic next_q(logic q, logic en, logic [1:0] dm, logic fs,
                                    logic fr, logic sev, logic rev);
        if (!en) return (dm == 2'd1) ? 1'b1 : (dm == 2'd2) ? q : 1'b0;
        if (fr)  return 1'b0;
        if (fs)  return 1'b1;
        if (rev) return 1'b0;
        if (sev) return 1'b1;
        return q;
    endfunction

    function automatic string tag_of(logic en, logic [1:0] dm, logic fs, logic fr,
                                     logic sev, logic rev);
        if (!en) return (dm == 2'd1) ? "R6" : (dm == 2'd2) ? "R7" : "R5";
        if (fs && fr) return "R9";
        if (fs || fr) return "R8";
        if (sev && rev) return "R9";
        if (rev) return "R2";
        if (sev) return "R1";
        return "R11";
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: q_out=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // inputs already driven; advance one clock and compare
    task automatic step(string tag);
        logic sev, rev, cs, cr;
        string t;
        cs  = bit_bus[set_sel];
        cr  = bit_bus[rst_sel];
        sev = edge_hit(set_edge, cs, m_ps);
        rev = edge_hit(rst_edge, cr, m_pr);
        t   = (tag == "") ? tag_of(enable, dis_mode, force_set, force_rst, sev, rev) : tag;
        m_q = next_q(m_q, enable, dis_mode, force_set, force_rst, sev, rev);
        m_ps = cs;
        m_pr = cr;
        @(posedge clk);
        #1;
        check(t, q_out, m_q);
        @(negedge clk);
    endtask

    task automatic quiet();
        force_set = 1'b0;
        force_rst = 1'b0;
        enable    = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed = 32'h5eed_1234;
        void'($urandom(seed));
        rst = 1'b1;
        bit_bus = '0;
        bit_bus[0] = 1'b1;
        set_sel = 5'd0; rst_sel = 5'd1;
        set_edge = 2'd0; rst_edge = 2'd0; dis_mode = 2'd0;
        enable = 1'b1; force_set = 1'b0; force_rst = 1'b0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        check("R10", q_out, 1'b0);
        rst = 1'b0;
        m_q = 1'b0; m_ps = 1'b0; m_pr = 1'b0;
        // R10: bit already high after reset is a rising edge
        step("R10");
        check("R10", q_out, 1'b1);

        // R2: clear on rising edge of source 1
        bit_bus[1] = 1'b1; step("R2");
        check("R2", q_out, 1'b0);
        // R3: falling setting on set source, independent of clear source
        set_edge = 2'd1; bit_bus[0] = 1'b0; step("R3");
        check("R3", q_out, 1'b1);
        // R3: edge off ignores edges
        rst_edge = 2'd3; bit_bus[1] = 1'b0; step("R3");
        bit_bus[1] = 1'b1; step("R3");
        check("R3", q_out, 1'b1);
        // R3: either edge
        rst_edge = 2'd2; bit_bus[1] = 1'b0; step("R3");
        check("R3", q_out, 1'b0);

        // R4: rising edge coincides with change to falling -> ignored
        set_edge = 2'd0; step("R4");
        set_edge = 2'd1; bit_bus[0] = 1'b1; step("R4");
        check("R4", q_out, 1'b0);
        bit_bus[0] = 1'b0; step("R4");
        check("R4", q_out, 1'b1);
        // R4: falling edge with change to falling is taken
        force_rst = 1'b1; step("R8"); force_rst = 1'b0;
        set_edge = 2'd0; bit_bus[0] = 1'b1; step("R1");
        check("R1", q_out, 1'b1);
        force_rst = 1'b1; step("R8"); force_rst = 1'b0;
        set_edge = 2'd1; bit_bus[0] = 1'b0; step("R4");
        check("R4", q_out, 1'b1);

        // R9: simultaneous strobes and simultaneous bus edges
        force_set = 1'b1; force_rst = 1'b1; step("R9");
        check("R9", q_out, 1'b0);
        quiet();
        set_edge = 2'd2; rst_edge = 2'd2; set_sel = 5'd4; rst_sel = 5'd5;
        step("R11");
        force_set = 1'b1; step("R8"); force_set = 1'b0;
        bit_bus[4] = 1'b1; bit_bus[5] = 1'b1; step("R9");
        check("R9", q_out, 1'b0);
        // R8: strobe beats bus clear edge
        bit_bus[5] = 1'b0; force_set = 1'b1; step("R8");
        check("R8", q_out, 1'b1);
        quiet();

        // R5/R6/R7 with events present
        enable = 1'b0; dis_mode = 2'd2; force_rst = 1'b1; bit_bus[5] = 1'b1; step("R7");
        check("R7", q_out, 1'b1);
        force_rst = 1'b0; dis_mode = 2'd0; force_set = 1'b1; bit_bus[4] = 1'b0; step("R5");
        check("R5", q_out, 1'b0);
        dis_mode = 2'd1; force_set = 1'b0; force_rst = 1'b1; step("R6");
        check("R6", q_out, 1'b1);
        dis_mode = 2'd3; step("R5");
        check("R5", q_out, 1'b0);
        quiet();

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            bit_bus   = BUS_W'($urandom());
            if ($urandom_range(3) == 0) set_sel = SEL_W'($urandom_range(7));
            if ($urandom_range(3) == 0) rst_sel = SEL_W'($urandom_range(7));
            if ($urandom_range(7) == 0) set_edge = 2'($urandom_range(3));
            if ($urandom_range(7) == 0) rst_edge = 2'($urandom_range(3));
            if ($urandom_range(7) == 0) dis_mode = 2'($urandom_range(3));
            enable    = ($urandom_range(9) != 0);
            force_set = ($urandom_range(11) == 0);
            force_rst = ($urandom_range(13) == 0);
            step("");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule